// File: doc/BRIEF.md
# Fan Drive PWM with Cycle Latch and Over-Current Cut-Off

This block generates the per-cycle drive enable for a fan motor power stage. Each drive cycle is timed either by an internal free-running counter, whose value is compared against a duty word derived from a speed command, or by an external digital duty-cycle pulse train when digital mode is selected. Within one cycle the output can turn on only once. A synchronous over-current flag ends the on-time immediately, and the output then stays off until the next cycle of the active timebase begins.

Around the basic modulator the block supports several mapping options. A slope-select input reverses the command-to-duty mapping. An optional minimum-duty floor applies in counter mode. A full-drive setting keeps the output on for the whole cycle, which suits commutation-only use. A supervisor enable turns off everything. The asynchronous over-current and pulse inputs are each synchronized by two flops inside the block.

Top module: `fan_pwm_latch`

## Requirements
- R1: While `en` is low, `drive_out` is 0, the counter is held at zero, and any stored over-current state is cleared.
- R2: In counter mode (`digital_mode`=0, `full_on`=0) a cycle lasts 2^CNT_W clocks. Cycle clock k (k = 0 .. 2^CNT_W-1) drives high exactly when k < duty. After `en` rises, the first cycle starts in the clock in which `en` is first seen high.
- R3: The duty is taken from the command in the first clock of each cycle. A change of `cmd`, `slope_dn` or `floor_en` later in the same cycle has no effect until the next cycle.
- R4: With `slope_dn`=0 the mapped duty equals `cmd`. With `slope_dn`=1 it equals 2^CNT_W-1-`cmd`.
- R5: In counter mode with `floor_en`=1, the duty is max(mapped duty, MIN_DUTY); MIN_DUTY is 90 of 256 by default, about 35 %. With `floor_en`=0 the mapped duty is used unchanged.
- R6: `ilim` is synchronized by two flops. When its synchronized value is 1, `drive_out` is 0 in that same clock. A level on `ilim` in clock k therefore blocks the drive from clock k+2.
- R7: Once an over-current has been seen, `drive_out` stays 0 until the next cycle start, even after `ilim` has returned to 0.
- R8: In digital mode (`digital_mode`=1, `full_on`=0), `drive_out` follows `ext_pulse` delayed by two clocks. A cycle starts at each rising edge of the synchronized pulse, and that edge clears the over-current state. The minimum-duty floor has no effect in this mode.
- R9: With `full_on`=1, `drive_out` is 1 in every clock of each counter cycle, subject only to R1, R6 and R7.
- R10: While `en` and the mode inputs stay constant, `drive_out` can rise only in the first clock of a cycle, so a cycle never carries a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Supervisor enable; low forces the drive off |
| digital_mode | input | 1 | 1 selects the external pulse train as the timebase |
| slope_dn | input | 1 | 1 selects the decreasing command-to-duty mapping |
| floor_en | input | 1 | Enables the minimum-duty floor in counter mode |
| full_on | input | 1 | Full drive in every cycle, with no speed input |
| cmd | input | CNT_W | Speed command word |
| ext_pulse | input | 1 | External duty-cycle pulse train (asynchronous) |
| ilim | input | 1 | Over-current comparator flag (asynchronous) |
| drive_out | output | 1 | Drive enable to the power stage |

## Verification
The hardest case to produce at the ports is an over-current flag that asserts and then clears in the middle of an on-time. The case must be followed through the cycle boundary, to show both that the output stays off for the rest of the cycle and that it recovers exactly at the next start. The stimulus pulses `ilim` for a few clocks at a chosen offset inside a long duty window. It then runs a second counter cycle without interruption, and in digital mode it places the flag inside one pulse of a train. Randomized periods with mid-cycle command changes cover sampling of the duty at the cycle start.

// File: rtl/fan_pwm_latch.sv
module fan_pwm_latch #(
  parameter int CNT_W    = 8,
  parameter int MIN_DUTY = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             digital_mode,
  input  logic             slope_dn,
  input  logic             floor_en,
  input  logic             full_on,
  input  logic [CNT_W-1:0] cmd,
  input  logic             ext_pulse,
  input  logic             ilim,
  output logic             drive_out
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DUTY);

  logic [1:0]       ilim_sync, pulse_sync;
  logic             pulse_d, lim_q;
  logic [CNT_W-1:0] cnt, duty_q;

  wire ilim_s    = ilim_sync[1];
  wire pulse_s   = pulse_sync[1];
  wire osc_tb    = !digital_mode || full_on;
  wire osc_start = (cnt == '0);
  wire start     = osc_tb ? osc_start : (pulse_s && !pulse_d);

  wire [CNT_W-1:0] mapped    = slope_dn ? ~cmd : cmd;
  wire [CNT_W-1:0] duty_next = (floor_en && !digital_mode && mapped < FLOOR) ? FLOOR : mapped;
  wire [CNT_W-1:0] duty_now  = osc_start ? duty_next : duty_q;

  wire on      = full_on ? 1'b1 : (digital_mode ? pulse_s : (cnt < duty_now));
  wire lim_eff = lim_q && !start;

  assign drive_out = en && on && !ilim_s && !lim_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilim_sync  <= '0;
      pulse_sync <= '0;
      pulse_d    <= 1'b0;
      cnt        <= '0;
      duty_q     <= '0;
      lim_q      <= 1'b0;
    end else begin
      ilim_sync  <= {ilim_sync[0], ilim};
      pulse_sync <= {pulse_sync[0], ext_pulse};
      pulse_d    <= pulse_s;
      if (!en) begin
        cnt    <= '0;
        duty_q <= '0;
        lim_q  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (osc_start) duty_q <= duty_next;
        if (ilim_s)     lim_q <= 1'b1;
        else if (start) lim_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fan_pwm_latch_chk.sv
module fan_pwm_latch_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic digital_mode,
  input logic full_on,
  input logic pulse_s,
  input logic ilim_s,
  input logic lim_q,
  input logic start,
  input logic drive_out
);
  p_disabled_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !drive_out);

  p_ilim_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_s |-> !drive_out);

  p_ilim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_s && en) |=> lim_q);

  p_latched_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q && !start) |-> !drive_out);

  p_digital_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (digital_mode && !full_on && !pulse_s) |-> !drive_out);

  p_one_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drive_out) && $stable(en) && $stable(digital_mode) && $stable(full_on)) |-> start);
endmodule

bind fan_pwm_latch fan_pwm_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .digital_mode(digital_mode),
  .full_on(full_on), .pulse_s(pulse_s), .ilim_s(ilim_s), .lim_q(lim_q),
  .start(start), .drive_out(drive_out)
);

// File: tb/fan_pwm_latch_tb.sv
module fan_pwm_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 1 << W;
  localparam int MIN_D = 90;

  logic clk = 0, rst_n = 0, en = 0, digital_mode = 0, slope_dn = 0, floor_en = 0, full_on = 0;
  logic [W-1:0] cmd = '0;
  logic ext_pulse = 0, ilim = 0;
  logic drive_out;
  int checks = 0, errors = 0;
  bit done = 0;

  fan_pwm_latch #(.CNT_W(W), .MIN_DUTY(MIN_D)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .digital_mode(digital_mode),
    .slope_dn(slope_dn), .floor_en(floor_en), .full_on(full_on), .cmd(cmd),
    .ext_pulse(ext_pulse), .ilim(ilim), .drive_out(drive_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_duty(input int c, input bit sd, input bit fl);
    int m = sd ? (N - 1 - c) : c;
    if (fl && m < MIN_D) m = MIN_D;
    return m;
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_analog(input int c, input bit sd, input bit fl, input bit fo,
                            input int nper, input int ilim_at, input bit mid_change, input string req);
    int duty = exp_duty(c, sd, fl);
    @(negedge clk); en = 0;
    @(negedge clk);
    digital_mode = 0; cmd = W'(c); slope_dn = sd; floor_en = fl; full_on = fo; en = 1;
    for (int p = 0; p < nper; p++) begin
      int bad = 0, highs = 0, rises = 0, ehigh = 0;
      bit prev = 0;
      for (int i = 0; i < N; i++) begin
        bit e;
        if (p > 0 || i > 0) @(negedge clk);
        if (p == 0 && i == ilim_at) ilim = 1;
        if (p == 0 && ilim_at >= 0 && i == ilim_at + 3) ilim = 0;
        if (mid_change && i == 5) begin
          cmd = W'($urandom_range(0, N - 1)); slope_dn = $urandom_range(0, 1); floor_en = $urandom_range(0, 1);
        end
        if (mid_change && i == N - 1) begin
          cmd = W'(c); slope_dn = sd; floor_en = fl;
        end
        #1;
        e = (fo || i < duty) && !(p == 0 && ilim_at >= 0 && i >= ilim_at + 2);
        if (drive_out !== e) bad++;
        if (drive_out) highs++;
        if (e) ehigh++;
        if (drive_out && !prev) rises++;
        prev = drive_out;
      end
      check(bad == 0 && highs == ehigh && rises <= 1, req, highs, ehigh);
    end
  endtask

  task automatic run_digital(input int npulse, input int ilim_pulse, input int ilim_off, input string req);
    bit p1 = 0, p2 = 0, p3 = 0, c1 = 0, c2 = 0, lim_m = 0;
    int bad = 0, highs = 0, ehigh = 0;
    @(negedge clk); en = 0; ext_pulse = 0; ilim = 0;
    @(negedge clk); digital_mode = 1; full_on = 0; floor_en = 1; cmd = '0; en = 1;
    for (int k = 0; k < npulse; k++) begin
      int hi = $urandom_range(10, 30);
      int lo = $urandom_range(5, 20);
      for (int i = 0; i < hi + lo; i++) begin
        bit e, st;
        @(negedge clk);
        ext_pulse = (i < hi);
        ilim = (k == ilim_pulse && i >= ilim_off && i < ilim_off + 2);
        #1;
        st = p2 && !p3;
        e = p2 && !c2 && !(lim_m && !st);
        if (c2) lim_m = 1; else if (st) lim_m = 0;
        if (drive_out !== e) bad++;
        if (drive_out) highs++;
        if (e) ehigh++;
        p3 = p2; p2 = p1; p1 = ext_pulse;
        c2 = c1; c1 = ilim;
      end
    end
    check(bad == 0 && highs == ehigh, req, highs, ehigh);
    ext_pulse = 0; ilim = 0; digital_mode = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1 check(drive_out === 1'b0, "R1 reset", drive_out, 0);
    rst_n = 1;
    @(negedge clk); cmd = '1;
    @(negedge clk); #1 check(drive_out === 1'b0, "R1 en low", drive_out, 0);

    run_analog(128, 0, 0, 0, 1, -1, 0, "R2 half duty");
    run_analog(0,   0, 0, 0, 1, -1, 0, "R2 zero duty");
    run_analog(200, 1, 0, 0, 1, -1, 0, "R4 slope down");
    run_analog(20,  0, 1, 0, 1, -1, 0, "R5 floor raises");
    run_analog(255, 1, 1, 0, 1, -1, 0, "R5 floor on slope down");
    run_analog(150, 0, 1, 0, 1, -1, 0, "R5 floor above min");
    run_analog(200, 0, 0, 0, 2, 20, 0, "R6 R7 ilim cut then recover");
    run_analog(0,   0, 0, 1, 1, -1, 0, "R9 full on");
    run_analog(0,   0, 0, 1, 2, 100, 0, "R9 R7 full on with ilim");

    for (int r = 0; r < 12; r++)
      run_analog($urandom_range(0, N - 1), $urandom_range(0, 1), $urandom_range(0, 1),
                 0, 2, -1, 1, "R3 R10 random with mid-cycle change");

    run_digital(5, -1, 0, "R8 digital follow");
    run_digital(5, 2, 6, "R8 R7 digital ilim cleared at edge");

    @(negedge clk); cmd = '1; full_on = 1; en = 0;
    @(negedge clk); #1 check(drive_out === 1'b0, "R1 disable during full on", drive_out, 0);
    done = 1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule